// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a flash status port. It finds out whether an embedded program or erase operation has finished by watching a toggle bit. The bit flips on every status read while the operation is running and stays still once the operation is over. After a `start` pulse the poller reads the status byte twice in a row and compares bit 6 between the two reads. A match means the operation is complete, and the poller pulses `done`. A mismatch means the operation is still running, and the poller reads another pair. The exception is when the limit bit (bit 5) is set in the second byte of the pair. Toggling may have stopped just as that bit rose, so the poller reads one confirming pair. If that pair still toggles, the operation has failed.

On failure the poller pulses `err` and, in the same cycle, issues one write of the reset command byte F0h so that the device goes back to array read. A programmable ceiling on the number of compared pairs keeps a device that never settles from hanging the poller. When that ceiling is hit, `err` is raised together with `err_timeout`. A new `start` while polling is under way abandons the current attempt. The poller then begins again from the initial double read and throws away any read still in flight.

Top module: `tbp_poller`

## Requirements
- R1: After an accepted `start`, the poller issues two status reads to the latched `poll_addr`, one at a time, before it makes any decision.
- R2: If bit 6 is the same in both bytes of a pair, `done` pulses in the cycle after the second byte is accepted and no further read is issued. Only bit 6 is compared; the other bits do not affect the result.
- R3: If bit 6 differs, bit 5 of the second byte is 0 and the ceiling is not reached, the poller starts a fresh pair of reads.
- R4: If bit 6 differs and bit 5 of the second byte is 1, the poller reads one more pair. If bit 6 matches in that pair, `done` pulses.
- R5: If bit 6 still differs in that confirming pair, `err` pulses (with `err_timeout` low) in the cycle after the second byte is accepted. In the same cycle `wr_req` pulses with `wr_data` = F0h and `wr_addr` = the latched address. A later `start` polls normally.
- R6: A `start` while polling is under way restarts from the initial double read. The restart clears both the pair count and any pending confirmation, and discards the response to a read already in flight.
- R7: On a mismatching pair with bit 5 clear, if the number of pairs compared since `start` (this one included) is at least `poll_limit`, `err` and `err_timeout` pulse together with the reset write. A set bit 5 takes precedence over the ceiling.
- R8: At most one read is outstanding at a time, and `done` and `err` are one-cycle pulses that never coincide.
- R9: While reset is held and right after it is released, `rd_req`, `done`, `err`, `err_timeout` and `wr_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin (or restart) polling |
| poll_addr | input | AW | Status address, latched on an accepted start |
| poll_limit | input | CW | Ceiling on compared pairs before a timeout error |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Read address (latched status address) |
| rd_data | input | DW | Returned status byte |
| rd_valid | input | 1 | Strobe marking `rd_data` valid |
| done | output | 1 | Operation completed successfully (pulse) |
| err | output | 1 | Operation failed or timed out (pulse) |
| err_timeout | output | 1 | Qualifies `err` as a ceiling timeout |
| wr_req | output | 1 | One-cycle write request carrying the reset command |
| wr_addr | output | AW | Write address (latched status address) |
| wr_data | output | DW | Write data, the reset command byte F0h |

## Verification
The assertions assume that the read port returns exactly one `rd_valid` for each `rd_req`, that it does so one or more cycles after the request, and that it never returns an unsolicited strobe. They also assume that `start` is a single-cycle pulse. The bench's responder keeps within these rules. It holds a single pending slot, answers it after a fixed latency, and feeds the pre-loaded status bytes of each scenario in order. A restart is issued only while a read is pending, so the discarded response still arrives as the one strobe owed to that request.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef enum logic [2:0] {
    TBP_IDLE,
    TBP_REQ,
    TBP_WAIT,
    TBP_DONE,
    TBP_FAIL
  } tbp_state_e;

endpackage

// File: rtl/tbp_pair_cmp.sv
// Holds the toggle bit of the first read of a pair and compares it with the
// second read. Only one flop of storage is kept.
module tbp_pair_cmp #(
  parameter int DW      = 8,
  parameter int TOG_BIT = 6,
  parameter int LIM_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] smp,
  output logic          toggled,
  output logic          lim_set
);

  localparam logic [DW-1:0] TOG_MASK = DW'(1) << TOG_BIT;
  localparam logic [DW-1:0] LIM_MASK = DW'(1) << LIM_BIT;

  logic tog_now;
  logic first_q;
  logic first_d;

  assign tog_now = |(smp & TOG_MASK);
  assign lim_set = |(smp & LIM_MASK);
  assign first_d = cap_en ? tog_now : first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= 1'b0;
    else        first_q <= first_d;
  end

  assign toggled = first_q ^ tog_now;

endmodule

// File: rtl/tbp_pair_count.sv
// Counts compared pairs since start and flags when the ceiling is reached
// by the pair being compared now.
module tbp_pair_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          at_limit
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW:0]   cnt_plus;

  assign cnt_plus = {1'b0, cnt_q} + (CW+1)'(1);
  assign at_limit = cnt_plus >= {1'b0, limit};

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                          cnt_d = '0;
    else if (inc && cnt_q != CNT_MAX) cnt_d = cnt_plus[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tbp_poll_fsm.sv
// Sequencing of read pairs, the confirming pair after the limit bit,
// restart with discard of an in-flight response, and outcome selection.
module tbp_poll_fsm
  import tbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_valid,
  input  logic       toggled,
  input  logic       lim_set,
  input  logic       at_limit,
  output tbp_state_e state,
  output logic       cap_en,
  output logic       cnt_clr,
  output logic       cnt_inc,
  output logic       accept,
  output logic       tmo
);

  tbp_state_e st_q, st_d;
  logic idx_q, idx_d;     // 0: first read of pair pending, 1: second
  logic rck_q, rck_d;     // confirming pair in progress
  logic drop_q, drop_d;   // discard next response
  logic tmo_q, tmo_d;

  assign accept = start && (st_q != TBP_FAIL);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    rck_d   = rck_q;
    drop_d  = drop_q;
    tmo_d   = tmo_q;
    cap_en  = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (st_q)
      TBP_IDLE, TBP_DONE, TBP_FAIL: begin
        st_d = TBP_IDLE;
        if (accept) begin
          st_d    = TBP_REQ;
          idx_d   = 1'b0;
          rck_d   = 1'b0;
          drop_d  = 1'b0;
          tmo_d   = 1'b0;
          cnt_clr = 1'b1;
        end
      end
      TBP_REQ: begin
        st_d = TBP_WAIT;
        if (start) begin
          idx_d   = 1'b0;
          rck_d   = 1'b0;
          drop_d  = 1'b1;
          cnt_clr = 1'b1;
        end
      end
      TBP_WAIT: begin
        if (start) begin
          idx_d   = 1'b0;
          rck_d   = 1'b0;
          cnt_clr = 1'b1;
          if (rd_valid) begin
            drop_d = 1'b0;
            st_d   = TBP_REQ;
          end else begin
            drop_d = 1'b1;
          end
        end else if (rd_valid) begin
          if (drop_q) begin
            drop_d = 1'b0;
            st_d   = TBP_REQ;
          end else if (!idx_q) begin
            cap_en = 1'b1;
            idx_d  = 1'b1;
            st_d   = TBP_REQ;
          end else begin
            cnt_inc = 1'b1;
            idx_d   = 1'b0;
            if (!toggled) begin
              st_d = TBP_DONE;
            end else if (rck_q) begin
              tmo_d = 1'b0;
              st_d  = TBP_FAIL;
            end else if (lim_set) begin
              rck_d = 1'b1;
              st_d  = TBP_REQ;
            end else if (at_limit) begin
              tmo_d = 1'b1;
              st_d  = TBP_FAIL;
            end else begin
              st_d = TBP_REQ;
            end
          end
        end
      end
      default: st_d = TBP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TBP_IDLE;
      idx_q  <= 1'b0;
      rck_q  <= 1'b0;
      drop_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      rck_q  <= rck_d;
      drop_q <= drop_d;
      tmo_q  <= tmo_d;
    end
  end

  assign state = st_q;
  assign tmo   = tmo_q;

endmodule

// File: rtl/tbp_poller.sv
module tbp_poller
  import tbp_pkg::*;
#(
  parameter int              AW        = 17,
  parameter int              DW        = 8,
  parameter int              CW        = 16,
  parameter int              TOG_BIT   = 6,
  parameter int              LIM_BIT   = 5,
  parameter logic [DW-1:0]   RESET_CMD = 'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] poll_addr,
  input  logic [CW-1:0] poll_limit,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_valid,
  output logic          done,
  output logic          err,
  output logic          err_timeout,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  tbp_state_e    state;
  logic          cap_en;
  logic          cnt_clr;
  logic          cnt_inc;
  logic          accept;
  logic          tmo;
  logic          toggled;
  logic          lim_set;
  logic          at_limit;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;

  tbp_poll_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_valid (rd_valid),
    .toggled  (toggled),
    .lim_set  (lim_set),
    .at_limit (at_limit),
    .state    (state),
    .cap_en   (cap_en),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .accept   (accept),
    .tmo      (tmo)
  );

  tbp_pair_cmp #(
    .DW      (DW),
    .TOG_BIT (TOG_BIT),
    .LIM_BIT (LIM_BIT)
  ) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .smp     (rd_data),
    .toggled (toggled),
    .lim_set (lim_set)
  );

  tbp_pair_count #(
    .CW (CW)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .limit    (poll_limit),
    .at_limit (at_limit)
  );

  assign addr_d = accept ? poll_addr : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign rd_req      = (state == TBP_REQ);
  assign rd_addr     = addr_q;
  assign done        = (state == TBP_DONE);
  assign err         = (state == TBP_FAIL);
  assign err_timeout = (state == TBP_FAIL) && tmo;
  assign wr_req      = (state == TBP_FAIL);
  assign wr_addr     = addr_q;
  assign wr_data     = RESET_CMD;

endmodule

// File: rtl/tbp_poller_chk.sv
module tbp_poller_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_req,
  input logic rd_valid,
  input logic done,
  input logic err
);

  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= 1'b0;
    else if (rd_req)   out_q <= 1'b1;
    else if (rd_valid) out_q <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !out_q); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R8
  AST_DECIDE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> $past(rd_valid)); // R2
  AST_NO_READ_ON_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !rd_req); // R2

endmodule

bind tbp_poller tbp_poller_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req   (rd_req),
  .rd_valid (rd_valid),
  .done     (done),
  .err      (err)
);

// File: tb/tbp_poller_bench.sv
module tbp_poller_bench;

  localparam int AW  = 17;
  localparam int DW  = 8;
  localparam int CW  = 16;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic [CW-1:0] poll_limit = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic          rd_valid = 1'b0;
  logic          done, err, err_timeout, wr_req;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  always #2 clk = ~clk;

  tbp_poller u_tbp_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_addr(poll_addr),
    .poll_limit(poll_limit), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
    .err_timeout(err_timeout), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] stat_q[$];
  int    cur_id = 0;
  int    exp_reads = 0;
  int    exp_res = 0;     // 0 done, 1 fail, 2 timeout
  int    delivered = 0;
  int    requested = 0;
  bit    pend = 0;
  int    pend_cnt = 0;
  logic [7:0] pend_dat = '0;
  int    pend_id = 0;
  bit    final_prev = 0;
  bit    outcome_seen = 0;
  string cur_tag = "R9";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural prediction of the outcome from the status byte stream.
  function automatic void predict(input logic [7:0] b[$], input int lim,
                                  output int reads, output int res);
    int i = 0;
    int pairs = 0;
    bit rck = 0;
    logic [7:0] x, y;
    reads = 0;
    res = 0;
    for (int p = 0; p < 1000; p++) begin
      x = (i < b.size()) ? b[i] : 8'h00;
      y = (i + 1 < b.size()) ? b[i+1] : 8'h00;
      i += 2;
      pairs++;
      if (x[6] == y[6]) begin res = 0; reads = i; return; end
      if (rck) begin res = 1; reads = i; return; end
      if (y[5]) rck = 1;
      else if (pairs >= lim) begin res = 2; reads = i; return; end
    end
  endfunction

  // Per-cycle reference comparison and read responder.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_tag, {31'd0, done}, {31'd0, final_prev && exp_res == 0});
      chk(cur_tag, {31'd0, err}, {31'd0, final_prev && exp_res != 0});
      chk(cur_tag, {31'd0, wr_req}, {31'd0, final_prev && exp_res != 0});
      if (final_prev && exp_res != 0) begin
        chk("R7", {31'd0, err_timeout}, {31'd0, exp_res == 2});
        chk("R5", {24'd0, wr_data}, 32'h0000_00F0);
        chk("R5", {15'd0, wr_addr}, {15'd0, poll_addr});
      end
      if (done || err) outcome_seen = 1;
      final_prev = 0;
      rd_valid = 1'b0;
      if (pend) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          rd_valid = 1'b1;
          rd_data  = pend_dat;
          pend     = 0;
          if (pend_id == cur_id) begin
            delivered++;
            if (delivered == exp_reads) final_prev = 1;
          end
        end
      end
      if (rd_req) begin
        chk("R8", {31'd0, pend}, 32'd0);
        chk("R1", {15'd0, rd_addr}, {15'd0, poll_addr});
        pend     = 1;
        pend_cnt = LAT;
        pend_id  = cur_id;
        pend_dat = (stat_q.size() > 0) ? stat_q.pop_front() : 8'h00;
        requested++;
      end
    end
  end

  task automatic load(string tag, logic [7:0] bytes[$], int lim, int addr);
    stat_q    = bytes;
    cur_id++;
    delivered = 0;
    requested = 0;
    predict(bytes, lim, exp_reads, exp_res);
    poll_limit = CW'(lim);
    poll_addr  = AW'(addr);
    cur_tag    = tag;
    outcome_seen = 0;
    start = 1'b1;
  endtask

  task automatic finish_run(string tag);
    int w = 0;
    @(negedge clk); #1;
    start = 1'b0;
    while (!outcome_seen && w < 500) begin
      @(negedge clk); #1;
      w++;
    end
    if (!outcome_seen) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: actual no outcome expected outcome (scenario watchdog)", tag);
    end
    repeat (6) @(negedge clk);
    #1;
    chk(tag, requested, exp_reads);
  endtask

  task automatic run(string tag, logic [7:0] bytes[$], int lim, int addr);
    @(negedge clk); #1;
    load(tag, bytes, lim, addr);
    finish_run(tag);
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", {28'd0, rd_req, done, err, wr_req}, 32'd0);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R9", {27'd0, rd_req, done, err, err_timeout, wr_req}, 32'd0);

    run("R1", '{8'h00, 8'h00}, 8, 'h00010);
    run("R2", '{8'h7F, 8'h40}, 8, 'h1C002);
    for (int k = 1; k <= 4; k++) begin
      logic [7:0] q[$];
      q = {};
      for (int j = 0; j < k; j++) begin q.push_back(8'h00); q.push_back(8'h40); end
      q.push_back(8'h40); q.push_back(8'h40);
      run("R3", q, 16, 'h04000 + k);
    end
    run("R4", '{8'h40, 8'h20, 8'h60, 8'h60}, 16, 'h08000);
    run("R5", '{8'h40, 8'h20, 8'h00, 8'h40}, 16, 'h0C001);
    run("R5", '{8'h00, 8'h00}, 16, 'h0C002);
    run("R7", '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40}, 3, 'h10000);
    run("R7", '{8'h40, 8'h20, 8'h40, 8'h40}, 1, 'h10001);
    run("R7", '{8'h00, 8'h40}, 1, 'h10002);

    // Restart while a read is in flight with a confirming pair armed.
    @(negedge clk); #1;
    load("R6", '{8'h40, 8'h20, 8'h40, 8'h00, 8'h40, 8'h00}, 16, 'h14000);
    @(negedge clk); #1;
    start = 1'b0;
    begin
      int w = 0;
      while (!(requested == 3 && pend) && w < 200) begin
        @(negedge clk); #1;
        w++;
      end
    end
    load("R6", '{8'h40, 8'h00, 8'h40, 8'h40}, 16, 'h18000);
    finish_run("R6");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule